// File: doc/BRIEF.md
# Dual-Exponent Modular Power Sequencer

This block is the control unit of a double-base modular exponentiation engine. It computes g0^e0 · g1^e1 mod m without doing any arithmetic itself. It issues a stream of Montgomery multiplication commands to an external multiplier that owns a four-entry operand store:

| Slot | Contents |
|------|----------|
| 0 | g0 in Montgomery form |
| 1 | g1 in Montgomery form |
| 2 | the product g0·g1 |
| 3 | the accumulator, preset to R mod m |

Each command names an x slot, a y slot and a destination slot, and is launched with a one-cycle strobe. The multiplier answers with a one-cycle done strobe.

Both exponents are loaded into a small internal FIFO, 16 bits of each per word. In automatic mode a start strobe makes the block walk the two exponents together, from the most significant bit pair to the least significant. For every pair it squares the accumulator. If the pair is nonzero it then multiplies the accumulator by the precomputed operand that matches the pair. When the FIFO runs dry it pulses ready.

With automatic mode off, a start strobe instead launches one multiplication using the externally supplied slot selects. This is used for the conversions into and out of Montgomery form.

Top module: `simexp_sequencer`

## Requirements
- R1: During and directly after reset, ready, mul_start, fifo_full and fifo_nopush are all 0.
- R2: fifo_full is 1 while FIFO_DEPTH words are held. A push while full is dropped and raises fifo_nopush for exactly the next cycle. The dropped word never takes part in a run.
- R3: A FIFO word carries an e1 chunk in bits 31:16 and the e0 chunk of the same bit positions in bits 15:0. Words are pushed most significant chunk first, and word k of a run supplies exponent bits [16(n-1-k)+15 : 16(n-1-k)].
- R4: For every bit pair the first command is a squaring with x=3, y=3, dest=3. A run over n words issues exactly 16·n squarings.
- R5: The bit pair is written (e1,e0). After the squaring, pair 01 issues x=0, pair 10 issues x=1 and pair 11 issues x=2, each with y=3 and dest=3. Pair 00 issues no second command.
- R6: After an automatic run, slot 3 holds g0^e0 · g1^e1 mod m, as if the bits had been taken most significant first.
- R7: ready is a one-cycle pulse, two clock edges after the done strobe of the last command is sampled. No command is issued while ready is high.
- R8: An automatic start with an empty FIFO issues no command and pulses ready two clock edges after start is sampled.
- R9: A start with run_auto low issues exactly one command, carrying x_sel_single, y_sel_single and dest_single. ready follows two edges after its done strobe.
- R10: A start strobe while a run is in progress is ignored; the run's command count and result are unchanged.
- R11: At most one command is outstanding. mul_start is never high on two consecutive cycles, and a new command is issued only after the previous command's done strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_din | input | 32 | Exponent word: e1 chunk in 31:16, e0 chunk in 15:0 |
| fifo_push | input | 1 | Push fifo_din into the exponent FIFO |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH words |
| fifo_nopush | output | 1 | The previous cycle's push was rejected |
| start | input | 1 | One-cycle start strobe |
| run_auto | input | 1 | 1: exponentiation run, 0: single multiplication |
| x_sel_single | input | 2 | x slot for a single multiplication |
| y_sel_single | input | 2 | y slot for a single multiplication |
| dest_single | input | 2 | Destination slot for a single multiplication |
| mul_start | output | 1 | Command strobe to the multiplier |
| mul_x | output | 2 | x slot of the current command |
| mul_y | output | 2 | y slot of the current command |
| mul_dest | output | 2 | Destination slot of the current command |
| mul_done | input | 1 | Multiplier completion strobe |
| ready | output | 1 | One-cycle completion pulse |

## Verification
A wrong internal state shows up at the ports in one of four ways:

- A corrupted bit counter changes the number of squarings.
- A corrupted shift register or pair decode changes which x slots appear on the command bus.
- A wrong pop order scrambles the chunk order. This leaves the command counts intact but changes the final power.
- A stuck state machine either hangs without ready or pulses ready early, which shifts the ready timing relative to the last done strobe.

Every such fault is therefore visible within one run, at the latest when ready arrives. The bench compares the command tallies per slot, the ready timing and slot 3 against values computed by integer modular arithmetic. This is swept over many exponent patterns and over one to four words.

// File: rtl/simexp_pkg.sv
package simexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_ADVANCE,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_SQUARE,
        PH_MULT,
        PH_SINGLE
    } phase_e;

    typedef struct packed {
        logic [1:0] x;
        logic [1:0] y;
        logic [1:0] dest;
    } mul_cmd_t;

    // slot that holds the running accumulator
    localparam logic [1:0] ACC_SLOT = 2'd3;

endpackage

// File: rtl/simexp_fifo.sv
module simexp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         nopush
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             rej;
    } fifo_regs_t;

    fifo_regs_t f_d, f_q;
    logic [W-1:0] mem_q [DEPTH];
    logic accept, take;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (f_q.cnt == CNT_W'(DEPTH));
    assign empty  = (f_q.cnt == '0);
    assign head   = mem_q[f_q.rd];
    assign nopush = f_q.rej;
    assign accept = push && !full;
    assign take   = pop && !empty;

    always_comb begin
        f_d     = f_q;
        f_d.rej = push && full;
        if (accept) f_d.wr = ptr_inc(f_q.wr);
        if (take)   f_d.rd = ptr_inc(f_q.rd);
        case ({accept, take})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[f_q.wr] <= din;
    end

endmodule

// File: rtl/simexp_cmd_gen.sv
module simexp_cmd_gen
    import simexp_pkg::*;
(
    input  phase_e     phase,
    input  logic [1:0] pair,
    input  mul_cmd_t   single_cmd,
    output mul_cmd_t   cmd,
    output logic       pair_nz
);
    assign pair_nz = |pair;

    always_comb begin
        cmd.x    = ACC_SLOT;
        cmd.y    = ACC_SLOT;
        cmd.dest = ACC_SLOT;
        case (phase)
            PH_SINGLE: cmd   = single_cmd;
            // pair 01 -> slot 0, 10 -> slot 1, 11 -> slot 2
            PH_MULT:   cmd.x = pair - 2'd1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/simexp_sequencer.sv
module simexp_sequencer
    import simexp_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] fifo_din,
    input  logic              fifo_push,
    output logic              fifo_full,
    output logic              fifo_nopush,
    input  logic              start,
    input  logic              run_auto,
    input  logic [1:0]        x_sel_single,
    input  logic [1:0]        y_sel_single,
    input  logic [1:0]        dest_single,
    output logic              mul_start,
    output logic [1:0]        mul_x,
    output logic [1:0]        mul_y,
    output logic [1:0]        mul_dest,
    input  logic              mul_done,
    output logic              ready
);
    localparam int HALF_W = WORD_W / 2;
    localparam int BIT_W  = $clog2(HALF_W);

    typedef struct packed {
        seq_state_e        st;
        phase_e            ph;
        logic              auto_run;
        logic [HALF_W-1:0] e1_sh;
        logic [HALF_W-1:0] e0_sh;
        logic [BIT_W-1:0]  bits_left;
        mul_cmd_t          single;
        mul_cmd_t          cmd;
        logic              go;
        logic              rdy;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [WORD_W-1:0] fifo_head;
    logic              fifo_empty;
    logic              fifo_pop;
    logic [1:0]        cur_pair;
    logic              pair_nz;
    mul_cmd_t          next_cmd;
    logic              auto_busy;

    simexp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push   (fifo_push),
        .din    (fifo_din),
        .pop    (fifo_pop),
        .head   (fifo_head),
        .empty  (fifo_empty),
        .full   (fifo_full),
        .nopush (fifo_nopush)
    );

    assign cur_pair = {r_q.e1_sh[HALF_W-1], r_q.e0_sh[HALF_W-1]};

    simexp_cmd_gen u_cmd (
        .phase      (r_q.ph),
        .pair       (cur_pair),
        .single_cmd (r_q.single),
        .cmd        (next_cmd),
        .pair_nz    (pair_nz)
    );

    always_comb begin
        r_d      = r_q;
        r_d.go   = 1'b0;
        r_d.rdy  = 1'b0;
        fifo_pop = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!run_auto) begin
                        r_d.single   = '{x: x_sel_single, y: y_sel_single, dest: dest_single};
                        r_d.ph       = PH_SINGLE;
                        r_d.auto_run = 1'b0;
                        r_d.st       = ST_ISSUE;
                    end else if (fifo_empty) begin
                        r_d.st = ST_FINISH;
                    end else begin
                        r_d.e1_sh     = fifo_head[WORD_W-1:HALF_W];
                        r_d.e0_sh     = fifo_head[HALF_W-1:0];
                        r_d.bits_left = BIT_W'(HALF_W - 1);
                        r_d.ph        = PH_SQUARE;
                        r_d.auto_run  = 1'b1;
                        fifo_pop      = 1'b1;
                        r_d.st        = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                r_d.go  = 1'b1;
                r_d.cmd = next_cmd;
                r_d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                if (mul_done) begin
                    if (r_q.ph == PH_SINGLE) begin
                        r_d.st = ST_FINISH;
                    end else if (r_q.ph == PH_SQUARE && pair_nz) begin
                        r_d.ph = PH_MULT;
                        r_d.st = ST_ISSUE;
                    end else begin
                        r_d.st = ST_ADVANCE;
                    end
                end
            end
            ST_ADVANCE: begin
                r_d.ph = PH_SQUARE;
                if (r_q.bits_left != '0) begin
                    r_d.e1_sh     = r_q.e1_sh << 1;
                    r_d.e0_sh     = r_q.e0_sh << 1;
                    r_d.bits_left = r_q.bits_left - 1'b1;
                    r_d.st        = ST_ISSUE;
                end else if (fifo_empty) begin
                    r_d.rdy      = 1'b1;
                    r_d.auto_run = 1'b0;
                    r_d.st       = ST_IDLE;
                end else begin
                    r_d.e1_sh     = fifo_head[WORD_W-1:HALF_W];
                    r_d.e0_sh     = fifo_head[HALF_W-1:0];
                    r_d.bits_left = BIT_W'(HALF_W - 1);
                    fifo_pop      = 1'b1;
                    r_d.st        = ST_ISSUE;
                end
            end
            ST_FINISH: begin
                r_d.rdy = 1'b1;
                r_d.st  = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.ph <= PH_SQUARE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mul_start = r_q.go;
    assign mul_x     = r_q.cmd.x;
    assign mul_y     = r_q.cmd.y;
    assign mul_dest  = r_q.cmd.dest;
    assign ready     = r_q.rdy;
    assign auto_busy = r_q.auto_run;

endmodule

// File: rtl/simexp_sequencer_chk.sv
module simexp_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       fifo_push,
    input logic       fifo_full,
    input logic       fifo_nopush,
    input logic       mul_start,
    input logic [1:0] mul_y,
    input logic [1:0] mul_dest,
    input logic       ready,
    input logic       auto_busy
);
    p_single_issue_r11: assert property (@(posedge clk) disable iff (rst)
        mul_start |=> !mul_start);

    p_auto_acc_r5: assert property (@(posedge clk) disable iff (rst)
        (mul_start && auto_busy) |-> (mul_y == 2'd3 && mul_dest == 2'd3));

    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    p_ready_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ready |-> !mul_start);

    p_nopush_set_r2: assert property (@(posedge clk) disable iff (rst)
        (fifo_push && fifo_full) |=> fifo_nopush);

    p_nopush_clr_r2: assert property (@(posedge clk) disable iff (rst)
        !(fifo_push && fifo_full) |=> !fifo_nopush);

endmodule

bind simexp_sequencer simexp_sequencer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fifo_push   (fifo_push),
    .fifo_full   (fifo_full),
    .fifo_nopush (fifo_nopush),
    .mul_start   (mul_start),
    .mul_y       (mul_y),
    .mul_dest    (mul_dest),
    .ready       (ready),
    .auto_busy   (auto_busy)
);

// File: tb/simexp_sequencer_bench.sv
module simexp_sequencer_bench;
    localparam int  LAT = 3;
    localparam longint MOD = 65521;
    localparam longint G0  = 3;
    localparam longint G1  = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fifo_din = '0;
    logic        fifo_push = 1'b0;
    logic        fifo_full, fifo_nopush;
    logic        start = 1'b0;
    logic        run_auto = 1'b0;
    logic [1:0]  x_sel_single = '0, y_sel_single = '0, dest_single = '0;
    logic        mul_start;
    logic [1:0]  mul_x, mul_y, mul_dest;
    logic        mul_done = 1'b0;
    logic        ready;

    int     tests = 0;
    int     fails = 0;
    longint cyc = 0;
    longint last_done = 0;
    longint slot [4];
    int     xcount [4];
    int     ncmd = 0;
    bit     pend = 0;
    int     cdown = 0;
    bit     finished = 0;

    simexp_sequencer u_simexp_sequencer (
        .clk(clk), .rst(rst), .fifo_din(fifo_din), .fifo_push(fifo_push),
        .fifo_full(fifo_full), .fifo_nopush(fifo_nopush), .start(start),
        .run_auto(run_auto), .x_sel_single(x_sel_single),
        .y_sel_single(y_sel_single), .dest_single(dest_single),
        .mul_start(mul_start), .mul_x(mul_x), .mul_y(mul_y),
        .mul_dest(mul_dest), .mul_done(mul_done), .ready(ready)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // fixed-latency multiplier and operand store model
    initial begin
        forever begin
            @(negedge clk);
            mul_done = 1'b0;
            if (pend) begin
                if (cdown == 1) begin
                    mul_done  = 1'b1;
                    pend      = 0;
                    last_done = cyc;
                end else begin
                    cdown--;
                end
            end
            if (mul_start) begin
                slot[mul_dest] = (slot[mul_x] * slot[mul_y]) % MOD;
                xcount[mul_x]++;
                ncmd++;
                pend  = 1;
                cdown = LAT;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint modpow(input longint b, input logic [63:0] e);
        longint r = 1;
        for (int i = 63; i >= 0; i--) begin
            r = (r * r) % MOD;
            if (e[i]) r = (r * b) % MOD;
        end
        return r;
    endfunction

    task automatic init_slots();
        slot[0] = G0; slot[1] = G1; slot[2] = (G0 * G1) % MOD; slot[3] = 1;
        for (int i = 0; i < 4; i++) xcount[i] = 0;
        ncmd = 0;
    endtask

    task automatic push_words(input int n, input logic [63:0] e0, input logic [63:0] e1);
        for (int k = n - 1; k >= 0; k--) begin
            @(negedge clk);
            fifo_push = 1'b1;
            fifo_din  = {e1[16*k +: 16], e0[16*k +: 16]};
        end
        @(negedge clk);
        fifo_push = 1'b0;
    endtask

    task automatic pulse_start(input bit automode, output longint t0);
        @(negedge clk);
        run_auto = automode;
        start    = 1'b1;
        t0       = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_ready(input string req, output longint t_rdy);
        int guard = 0;
        while (!ready && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        t_rdy = cyc;
        check(ready == 1'b1, req, ready, 1);
        @(negedge clk);
        check(ready == 1'b0, req, ready, 0);
    endtask

    task automatic auto_run(input int n, input logic [63:0] a0, input logic [63:0] a1,
                            input bit poke);
        logic [63:0] e0, e1, mask;
        longint t0, tr, expv;
        int c0, c1, c2;
        mask = (n >= 4) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (16 * n)) - 1);
        e0 = a0 & mask;
        e1 = a1 & mask;
        c0 = $countones(e0 & ~e1);
        c1 = $countones(e1 & ~e0);
        c2 = $countones(e0 & e1);
        push_words(n, e0, e1);
        init_slots();
        pulse_start(1'b1, t0);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;                  // R10: strobe during a run
            @(negedge clk);
            start = 1'b0;
        end
        wait_ready("R7 ready pulse", tr);
        check(tr - last_done == 2, "R7 ready latency", tr - last_done, 2);
        expv = (modpow(G0, e0) * modpow(G1, e1)) % MOD;
        check(slot[3] == expv, poke ? "R10 result" : "R6 R3 result", slot[3], expv);
        check(xcount[3] == 16 * n, "R4 squarings", xcount[3], 16 * n);
        check(xcount[0] == c0 && xcount[1] == c1 && xcount[2] == c2, "R5 pair mults",
              xcount[0] * 10000 + xcount[1] * 100 + xcount[2], c0 * 10000 + c1 * 100 + c2);
    endtask

    initial begin
        longint t0, tr;
        init_slots();
        repeat (4) @(negedge clk);
        check(!ready && !mul_start && !fifo_full && !fifo_nopush, "R1 reset",
              {ready, mul_start, fifo_full, fifo_nopush}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!ready && !mul_start && !fifo_full && !fifo_nopush, "R1 after reset",
              {ready, mul_start, fifo_full, fifo_nopush}, 0);

        // R8: empty FIFO
        init_slots();
        pulse_start(1'b1, t0);
        wait_ready("R8 ready", tr);
        check(tr - t0 == 2, "R8 latency", tr - t0, 2);
        check(ncmd == 0, "R8 no command", ncmd, 0);

        // R9: single multiplication
        init_slots();
        x_sel_single = 2'd1; y_sel_single = 2'd0; dest_single = 2'd2;
        pulse_start(1'b0, t0);
        wait_ready("R9 ready", tr);
        check(tr - last_done == 2, "R9 latency", tr - last_done, 2);
        check(ncmd == 1, "R9 one command", ncmd, 1);
        check(slot[2] == (G0 * G1) % MOD && xcount[1] == 1, "R9 selects", slot[2], (G0 * G1) % MOD);
        init_slots();
        x_sel_single = 2'd3; y_sel_single = 2'd1; dest_single = 2'd0;
        pulse_start(1'b0, t0);
        wait_ready("R9 ready", tr);
        check(slot[0] == G1 && ncmd == 1, "R9 selects b", slot[0], G1);

        // R5 R6: sweep over small pair patterns at both ends of a word
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                auto_run(1, 64'(a) << 13 | 64'(a), 64'(b) << 13 | 64'(b), 1'b0);
        auto_run(1, 64'hFFFF, 64'h0000, 1'b0);
        auto_run(1, 64'h0000, 64'hFFFF, 1'b0);
        auto_run(1, 64'hFFFF, 64'hFFFF, 1'b0);

        // R3: multi-word chunk ordering
        auto_run(2, 64'h1234_8001, 64'hA5C3_0F0F, 1'b0);
        auto_run(3, 64'h0001_0000_8000, 64'h8000_0001_0000, 1'b0);
        auto_run(4, 64'hDEAD_BEEF_0123_4567, 64'h0F1E_2D3C_4B5A_6978, 1'b0);

        // R2: full and rejected push
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            fifo_push = 1'b1;
            fifo_din  = {16'(16'h1111 * (k + 1)), 16'(16'h0203 * (k + 1))};
        end
        @(negedge clk);
        check(fifo_full == 1'b1, "R2 full", fifo_full, 1);
        check(fifo_nopush == 1'b0, "R2 nopush idle", fifo_nopush, 0);
        fifo_din = 32'hFFFF_FFFF;
        @(negedge clk);
        fifo_push = 1'b0;
        check(fifo_nopush == 1'b1, "R2 nopush", fifo_nopush, 1);
        @(negedge clk);
        check(fifo_nopush == 1'b0, "R2 nopush one cycle", fifo_nopush, 0);
        begin
            logic [63:0] e0, e1;
            e0 = {16'h0203, 16'h0406, 16'h0609, 16'h080C};
            e1 = {16'h1111, 16'h2222, 16'h3333, 16'h4444};
            init_slots();
            pulse_start(1'b1, t0);
            wait_ready("R2 ready", tr);
            check(slot[3] == (modpow(G0, e0) * modpow(G1, e1)) % MOD, "R2 dropped word",
                  slot[3], (modpow(G0, e0) * modpow(G1, e1)) % MOD);
            check(xcount[3] == 64, "R2 word count", xcount[3], 64);
        end

        // R10: start strobe during a run
        auto_run(2, 64'h00F0_F00F, 64'h0F0F_3C3C, 1'b1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule